// File: doc/BRIEF.md
# Status and LED Output Mode Generator

This block drives one general-purpose output pin of a speech playback engine. The same RTL serves three output flavours, chosen at build time by a parameter (A, B or C). At run time a 2-bit option and a status/LED select pick how the pin behaves. In status form the pin reports playback: it follows the busy flag, holds a fixed level, or gives a timed pulse at the end of each sentence. In LED form the pin blinks at a fast or slow rate while audio plays, holds an on or off level, or lights an LED whenever the current sample's magnitude rises above a fixed fraction of full scale.

The playback engine supplies four signals: a busy flag, a one-cycle sentence-end pulse, the current unsigned sample magnitude and a sample-rate tick. The block counts time only in ticks. After reset the pin shows a selectable initial level, and it keeps that level until playback first starts.

Top module: `status_led_out_gen`

## Requirements
- R1: After reset, and until `busy_i` or `sent_end_i` is first seen high on a clock edge, `pin_o` equals `init_level_i`, whatever the mode.
- R2: After playback has started, status code 0 (all flavours) drives `pin_o` to the `busy_i` value sampled at the previous edge. Status code 2 on flavour C drives its inverse.
- R3: After playback has started, status code 1 gives a constant low and status code 3 gives a constant high, on every flavour.
- R4: Status code 2 on flavours A and B drives `pin_o` high from the edge that samples `sent_end_i` until the edge that samples the 256th following `tick_i`. A new `sent_end_i` reloads the full 256-tick width.
- R5: LED code 0 on flavours A and C outputs low for the first 512 ticks of busy time and then changes level every 512 ticks. Ticks count only while busy, and the count restarts from zero after each idle spell. While idle the output is high.
- R6: LED code 1 behaves as in R5 with a period of 2048 ticks instead of 512.
- R7: On flavour B, LED codes 0 and 1 are the exact inverse of R5 and R6: high first while busy, low while idle.
- R8: LED code 2 on flavour A is low when the sample exceeds 178 and high otherwise. On flavour B the limit is 229. The sample is compared as an unsigned 8-bit value at the previous edge.
- R9: LED code 3 is a constant high (off) on flavours A and C and a constant low (on) on flavour B. LED code 2 on flavour C is a constant low (on).
- R10: An active-low asynchronous reset returns all timers and the playback-started state to idle, so that `pin_o` shows `init_level_i` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| led_mode_i | input | 1 | 0 = status form, 1 = LED form |
| opt_i | input | 2 | Option code within the form |
| init_level_i | input | 1 | Pin level shown before playback starts |
| busy_i | input | 1 | Playback in progress |
| sent_end_i | input | 1 | One-cycle pulse at the end of a sentence |
| sample_i | input | SAMPLE_W | Current unsigned sample magnitude |
| tick_i | input | 1 | Sample-rate enable |
| pin_o | output | 1 | Driven output level |

## Verification
The hardest situation to reach is a slow-blink level change. It needs more than 2048 ticks of unbroken busy time, while irregular tick gaps must still be counted only when they occur. The stimulus holds busy for about 2700 cycles with one tick in seven dropped, and it sweeps the sample through every code along the way, so both amplitude limits are crossed repeatedly. The sentence-end pulse is retriggered while still active, and busy is dropped and raised again, to show that the blink count restarts from zero.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [3:0] {
        FN_BUSY_HI,
        FN_BUSY_LO,
        FN_CONST_LO,
        FN_CONST_HI,
        FN_PULSE,
        FN_FAST,
        FN_SLOW,
        FN_FAST_INV,
        FN_SLOW_INV,
        FN_AMP_LO,
        FN_AMP_HI
    } drive_fn_e;

    // fraction (num/10) of the full-scale code of a w-bit sample, rounded down
    function automatic int frac_of_full(int w, int num);
        return (((1 << w) - 1) * num) / 10;
    endfunction

endpackage

// File: rtl/sl_mode_decode.sv
module sl_mode_decode #(
    parameter int VARIANT = 0
) (
    input  logic                 led_mode_i,
    input  logic [1:0]           opt_i,
    output sl_pkg::drive_fn_e    fn_o
);
    import sl_pkg::*;

    generate
        if (VARIANT == 0) begin : g_var_a
            always_comb begin
                case ({led_mode_i, opt_i})
                    3'b000:  fn_o = FN_BUSY_HI;
                    3'b001:  fn_o = FN_CONST_LO;
                    3'b010:  fn_o = FN_PULSE;
                    3'b011:  fn_o = FN_CONST_HI;
                    3'b100:  fn_o = FN_FAST;
                    3'b101:  fn_o = FN_SLOW;
                    3'b110:  fn_o = FN_AMP_LO;
                    default: fn_o = FN_CONST_HI;
                endcase
            end
        end else if (VARIANT == 1) begin : g_var_b
            always_comb begin
                case ({led_mode_i, opt_i})
                    3'b000:  fn_o = FN_BUSY_HI;
                    3'b001:  fn_o = FN_CONST_LO;
                    3'b010:  fn_o = FN_PULSE;
                    3'b011:  fn_o = FN_CONST_HI;
                    3'b100:  fn_o = FN_FAST_INV;
                    3'b101:  fn_o = FN_SLOW_INV;
                    3'b110:  fn_o = FN_AMP_HI;
                    default: fn_o = FN_CONST_LO;
                endcase
            end
        end else begin : g_var_c
            always_comb begin
                case ({led_mode_i, opt_i})
                    3'b000:  fn_o = FN_BUSY_HI;
                    3'b001:  fn_o = FN_CONST_LO;
                    3'b010:  fn_o = FN_BUSY_LO;
                    3'b011:  fn_o = FN_CONST_HI;
                    3'b100:  fn_o = FN_FAST;
                    3'b101:  fn_o = FN_SLOW;
                    3'b110:  fn_o = FN_CONST_LO;
                    default: fn_o = FN_CONST_HI;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sl_tick_timers.sv
module sl_tick_timers #(
    parameter int FAST_LOG2   = 9,
    parameter int SLOW_LOG2   = 11,
    parameter int PULSE_TICKS = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic busy_i,
    input  logic sent_end_i,
    input  logic tick_i,
    output logic fast_ph_o,
    output logic slow_ph_o,
    output logic pulse_on_o
);
    localparam int CNT_W   = SLOW_LOG2 + 1;
    localparam int PULSE_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]   run;
        logic [PULSE_W-1:0] pulse;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!busy_i) begin
            tmr_d.run = '0;
        end else if (tick_i) begin
            tmr_d.run = tmr_q.run + 1'b1;
        end
        if (sent_end_i) begin
            tmr_d.pulse = PULSE_W'(PULSE_TICKS);
        end else if (tick_i && (tmr_q.pulse != '0)) begin
            tmr_d.pulse = tmr_q.pulse - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // phases are taken from the next state so the pin changes on the same edge
    assign fast_ph_o  = tmr_d.run[FAST_LOG2];
    assign slow_ph_o  = tmr_d.run[SLOW_LOG2];
    assign pulse_on_o = (tmr_d.pulse != '0);

endmodule

// File: rtl/status_led_out_gen.sv
module status_led_out_gen #(
    parameter int VARIANT     = 0,
    parameter int SAMPLE_W    = 8,
    parameter int FAST_LOG2   = 9,
    parameter int SLOW_LOG2   = 11,
    parameter int PULSE_TICKS = 256
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                led_mode_i,
    input  logic [1:0]          opt_i,
    input  logic                init_level_i,
    input  logic                busy_i,
    input  logic                sent_end_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                tick_i,
    output logic                pin_o
);
    import sl_pkg::*;

    localparam int THR_LO = frac_of_full(SAMPLE_W, 7);
    localparam int THR_HI = frac_of_full(SAMPLE_W, 9);

    typedef struct packed {
        logic started;
        logic drive;
    } out_s;

    out_s      out_d, out_q;
    drive_fn_e fn;
    logic      fast_ph, slow_ph, pulse_on;
    logic      fast_lvl, slow_lvl;

    sl_mode_decode #(.VARIANT(VARIANT)) i_decode (
        .led_mode_i (led_mode_i),
        .opt_i      (opt_i),
        .fn_o       (fn)
    );

    sl_tick_timers #(
        .FAST_LOG2   (FAST_LOG2),
        .SLOW_LOG2   (SLOW_LOG2),
        .PULSE_TICKS (PULSE_TICKS)
    ) i_timers (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .busy_i     (busy_i),
        .sent_end_i (sent_end_i),
        .tick_i     (tick_i),
        .fast_ph_o  (fast_ph),
        .slow_ph_o  (slow_ph),
        .pulse_on_o (pulse_on)
    );

    // non-inverted blink: low during the first phase, high while idle
    assign fast_lvl = busy_i ? fast_ph : 1'b1;
    assign slow_lvl = busy_i ? slow_ph : 1'b1;

    always_comb begin
        out_d         = out_q;
        out_d.started = out_q.started | busy_i | sent_end_i;
        case (fn)
            FN_BUSY_HI:  out_d.drive = busy_i;
            FN_BUSY_LO:  out_d.drive = ~busy_i;
            FN_CONST_LO: out_d.drive = 1'b0;
            FN_CONST_HI: out_d.drive = 1'b1;
            FN_PULSE:    out_d.drive = pulse_on;
            FN_FAST:     out_d.drive = fast_lvl;
            FN_SLOW:     out_d.drive = slow_lvl;
            FN_FAST_INV: out_d.drive = ~fast_lvl;
            FN_SLOW_INV: out_d.drive = ~slow_lvl;
            FN_AMP_LO:   out_d.drive = ~(sample_i > SAMPLE_W'(THR_LO));
            FN_AMP_HI:   out_d.drive = ~(sample_i > SAMPLE_W'(THR_HI));
            default:     out_d.drive = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{started: 1'b0, drive: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign pin_o = out_q.started ? out_q.drive : init_level_i;

endmodule

// File: rtl/sl_out_checker.sv
module sl_out_checker #(
    parameter int VARIANT     = 0,
    parameter int SAMPLE_W    = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                led_mode_i,
    input logic [1:0]          opt_i,
    input logic                init_level_i,
    input logic                busy_i,
    input logic                sent_end_i,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic                tick_i,
    input logic                pin_o
);
    localparam int LIM_LO = sl_pkg::frac_of_full(SAMPLE_W, 7);
    localparam int LIM_HI = sl_pkg::frac_of_full(SAMPLE_W, 9);

    logic seen_q;
    logic unused_tick;
    assign unused_tick = tick_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
        end else if (busy_i || sent_end_i) begin
            seen_q <= 1'b1;
        end
    end

    a_r1_init_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_q |-> (pin_o == init_level_i));

    a_r2_busy_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && !led_mode_i && opt_i == 2'd0) |=> (pin_o == $past(busy_i)));

    a_r3_const_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && !led_mode_i && opt_i == 2'd1) |=> !pin_o);

    a_r3_const_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && !led_mode_i && opt_i == 2'd3) |=> pin_o);

    generate
        if (VARIANT == 0 || VARIANT == 1) begin : g_pulse
            a_r4_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!led_mode_i && opt_i == 2'd2 && sent_end_i) |=> pin_o);
        end
        if (VARIANT == 0) begin : g_amp_a
            a_r8_amp_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && led_mode_i && opt_i == 2'd2 && sample_i > SAMPLE_W'(LIM_LO)) |=> !pin_o);
            a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && led_mode_i && opt_i == 2'd0 && !busy_i) |=> pin_o);
        end
        if (VARIANT == 1) begin : g_amp_b
            a_r8_amp_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && led_mode_i && opt_i == 2'd2 && sample_i > SAMPLE_W'(LIM_HI)) |=> !pin_o);
            a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && led_mode_i && opt_i == 2'd0 && !busy_i) |=> !pin_o);
        end
        if (VARIANT == 2) begin : g_var_c
            a_r2_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && !led_mode_i && opt_i == 2'd2) |=> (pin_o == !$past(busy_i)));
        end
    endgenerate

endmodule

bind status_led_out_gen sl_out_checker #(
    .VARIANT  (VARIANT),
    .SAMPLE_W (SAMPLE_W)
) i_sl_out_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .led_mode_i   (led_mode_i),
    .opt_i        (opt_i),
    .init_level_i (init_level_i),
    .busy_i       (busy_i),
    .sent_end_i   (sent_end_i),
    .sample_i     (sample_i),
    .tick_i       (tick_i),
    .pin_o        (pin_o)
);

// File: tb/test_status_led_out_gen.sv
module test_status_led_out_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       led_mode = 1'b0;
    logic [1:0] opt = 2'd0;
    logic       init_level = 1'b0;
    logic       busy = 1'b0;
    logic       sent_end = 1'b0;
    logic [7:0] sample = 8'd0;
    logic       tick = 1'b0;
    logic       pin_a, pin_b, pin_c;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    status_led_out_gen #(.VARIANT(0)) i_status_led_out_gen (
        .clk_i(clk), .rst_ni(rst_n), .led_mode_i(led_mode), .opt_i(opt),
        .init_level_i(init_level), .busy_i(busy), .sent_end_i(sent_end),
        .sample_i(sample), .tick_i(tick), .pin_o(pin_a));

    status_led_out_gen #(.VARIANT(1)) i_status_led_out_gen_b (
        .clk_i(clk), .rst_ni(rst_n), .led_mode_i(led_mode), .opt_i(opt),
        .init_level_i(init_level), .busy_i(busy), .sent_end_i(sent_end),
        .sample_i(sample), .tick_i(tick), .pin_o(pin_b));

    status_led_out_gen #(.VARIANT(2)) i_status_led_out_gen_c (
        .clk_i(clk), .rst_ni(rst_n), .led_mode_i(led_mode), .opt_i(opt),
        .init_level_i(init_level), .busy_i(busy), .sent_end_i(sent_end),
        .sample_i(sample), .tick_i(tick), .pin_o(pin_c));

    // ---------------- behavioural reference ----------------
    bit m_started = 1'b0;
    int m_run     = 0;   // busy ticks seen since busy rose, modulo 4096
    int m_pulse   = 0;   // ticks left in the sentence-end pulse
    bit s_busy = 1'b0, s_led = 1'b0;
    int s_opt = 0, s_sample = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_started = 1'b0; m_run = 0; m_pulse = 0;
            s_busy = 1'b0; s_led = 1'b0; s_opt = 0; s_sample = 0;
        end else begin
            if (busy || sent_end) m_started = 1'b1;
            if (!busy) m_run = 0;
            else if (tick) m_run = (m_run + 1) % 4096;
            if (sent_end) m_pulse = 256;
            else if (tick && m_pulse > 0) m_pulse = m_pulse - 1;
            s_busy = busy; s_led = led_mode; s_opt = int'(opt); s_sample = int'(sample);
        end
    end

    function automatic bit blink(int period, bit inv);
        bit lvl;
        lvl = s_busy ? (((m_run / period) % 2) == 1) : 1'b1;
        return inv ? !lvl : lvl;
    endfunction

    function automatic bit exp_drive(int v);
        if (!s_led) begin
            if (s_opt == 0) return s_busy;
            if (s_opt == 1) return 1'b0;
            if (s_opt == 3) return 1'b1;
            if (v == 2) return !s_busy;
            return m_pulse > 0;
        end
        if (s_opt == 0) return blink(512, v == 1);
        if (s_opt == 1) return blink(2048, v == 1);
        if (s_opt == 2) begin
            if (v == 0) return !(s_sample * 10 > 7 * 255);
            if (v == 1) return !(s_sample * 10 > 9 * 255);
            return 1'b0;
        end
        return v != 1;
    endfunction

    function automatic string req_tag(int v);
        if (!rst_n) return "R10";
        if (!m_started) return "R1";
        if (!s_led) begin
            case (s_opt)
                0: return "R2";
                1, 3: return "R3";
                default: return (v == 2) ? "R2" : "R4";
            endcase
        end
        case (s_opt)
            0: return (v == 1) ? "R7" : "R5";
            1: return (v == 1) ? "R7/R6" : "R6";
            2: return (v == 2) ? "R9" : "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_pin(int v, logic act);
        logic e;
        e = m_started ? exp_drive(v) : init_level;
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s variant=%0d led=%0d opt=%0d t=%0t actual=%0b expected=%0b",
                     req_tag(v), v, led_mode, opt, $time, act, e);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check_pin(0, pin_a);
            check_pin(1, pin_b);
            check_pin(2, pin_c);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog R1..all actual=%0d cycles expected<200000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic run_case(bit led, int o, bit init);
        rst_n = 1'b0;  // R10: reset brings pin back to init level
        busy = 1'b0; sent_end = 1'b0; tick = 1'b0; sample = 8'd0;
        led_mode = led; opt = 2'(o); init_level = init;
        repeat (3) step();
        rst_n = 1'b1;
        // R1: ticks and samples alone do not leave the initial level
        for (int i = 0; i < 6; i++) begin
            tick = 1'b1; sample = 8'(200 + i * 9);
            step();
        end
        init_level = !init;   // R1: pin follows the live init level
        step();
        // long busy spell: blinks (R5, R6, R7), amplitude sweep (R8), pulse while busy (R4)
        busy = 1'b1;
        for (int i = 0; i < 2700; i++) begin
            tick = (i % 7) != 3;
            sample = 8'(i);
            sent_end = (i == 600);
            step();
        end
        sent_end = 1'b0;
        busy = 1'b0;
        // idle: ticks must not advance blink count, pulse with retrigger (R4)
        for (int i = 0; i < 420; i++) begin
            tick = (i % 5) != 0;
            sent_end = (i == 3) || (i == 120);
            sample = 8'(255 - i);
            step();
        end
        sent_end = 1'b0;
        // busy again: blink restarts from its first phase (R5, R7)
        busy = 1'b1;
        for (int i = 0; i < 600; i++) begin
            tick = 1'b1;
            sample = 8'(170 + (i % 70));
            step();
        end
        busy = 1'b0;
        repeat (20) step();
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                run_case(bit'(m), o, bit'(o[0] ^ m[0]));
            end
        end
        // mid-run reset (R10), then R1 again with the other init level
        busy = 1'b1; step(); step();
        rst_n = 1'b0; busy = 1'b0; step();
        rst_n = 1'b1; init_level = 1'b1;
        repeat (5) step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule